// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers interrupt requests from a low-pin-count host controller and presents them to the rest of the chip as a single interrupt wire. The first level has a sticky status word. Seventeen serial-interrupt lines, a bus-reset-seen event, six sync-error events and two bus-master request events set bits in that word when they are high. Software clears the bits by writing ones. A level-one request exists when the enable bit in the serial-interrupt control register is set and any status bit that the level-one mask selects is pending.

The level-one request is registered into bit 11 of a second-level input word. The second level ORs (input AND its mask) into its own sticky status word on every clock. The chip interrupt output is high whenever that second status word is non-zero. The second level also stores two route words and a polarity word, and none of them changes the behaviour.

Both levels share one 32-bit register bus. Only word-aligned 4-byte accesses are decoded. Address bit 8 selects the level-one window when 1 and the level-two window when 0. Address bits 7:0 are the offset within the window. Read data arrives one clock after the request.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset, irq_out and bus_rvalid are low. The level-one firmware-read-size word (0x28) reads 0x02000000. Every other register reads 0.
- R2: A write, then a read, returns the last written value for these plain words. In the level-one window: 0x24 segment select, 0x28 firmware read size, 0x30 serial-interrupt control and 0x34 mask. In the level-two window: 0x08 and 0x0C routes, 0x54 mask and 0x58 polarity. In the control word, bit 31 is enable, bit 30 is quiet mode, and bits 25:24 give the start-frame width (0, 1 or 2 for 4, 6 or 8 clocks). A read returns data on bus_rdata together with bus_rvalid one clock after the request.
- R3: When serirq_lvl[n] is high at a clock edge, level-one status bit (31-n) is set. A low level never clears the bit.
- R4: Event inputs also latch into level-one status when high. lreset_seen sets bit 10. sync_err[5:0] sets bits 7:2: [5] abnormal, [4] no response, [3] normal, [2] timeout, [1] target turnaround, [0] bus-master turnaround. bm_req[1:0] sets bits 1:0. Bits 14:8, except bit 10, always read 0.
- R5: A write to level-one status (0x38) clears each bit written as one and leaves the bits written as zero unchanged. If a source is high in the same cycle as the clear, its bit stays set.
- R6: Level-two input (0x5C) bit 11 equals (control bit 31 AND (level-one status AND mask) != 0) as it stood one clock earlier. Its other bits read 0, and writes to 0x5C are ignored.
- R7: On every clock, level-two status (0x50) gains (input AND level-two mask). Writing ones to 0x50 clears those bits, but a bit that is being set in the same cycle stays set.
- R8: irq_out is high exactly when level-two status is non-zero. The polarity word has no effect on this.
- R9: The level-one error-address word (0x40) reads 0, and writes to it are ignored.
- R10: A read of an unmapped or misaligned address returns 0xFFFFFFFF. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Bit 8 selects the window (1 = level one); bits 7:0 are the byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after a read request |
| serirq_lvl | input | 17 | Decoded serial-interrupt line levels |
| lreset_seen | input | 1 | Bus-reset-seen event |
| sync_err | input | 6 | Sync error events |
| bm_req | input | 2 | Bus-master request events |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The collision that matters is a software clear of a status bit landing in the same cycle as a hardware set of that bit, and it can occur at both levels. At level one, the bench holds a serial line high across a write-one-to-clear of its bit. At level two, it holds a level-one request active across a clear of level-two bit 11. In each case a later read must still show the bit set. The bench then removes the source and repeats the clear, and the bit must read zero, which shows that the clear itself worked. A scoreboard compares every read result with the value derived from the requirements.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DW = 32;

  // level-one window offsets
  localparam logic [7:0] OFF_SEGSEL = 8'h24;
  localparam logic [7:0] OFF_FWSIZE = 8'h28;
  localparam logic [7:0] OFF_SCTRL  = 8'h30;
  localparam logic [7:0] OFF_HMASK  = 8'h34;
  localparam logic [7:0] OFF_HSTAT  = 8'h38;
  localparam logic [7:0] OFF_ERRADR = 8'h40;

  // level-two window offsets
  localparam logic [7:0] OFF_ROUTE0 = 8'h08;
  localparam logic [7:0] OFF_ROUTE1 = 8'h0C;
  localparam logic [7:0] OFF_LSTAT  = 8'h50;
  localparam logic [7:0] OFF_LMASK  = 8'h54;
  localparam logic [7:0] OFF_LPOL   = 8'h58;
  localparam logic [7:0] OFF_LIN    = 8'h5C;

  localparam logic [DW-1:0] FWSIZE_RST = 32'h0200_0000;
  localparam int EN_BIT      = 31;
  localparam int CASCADE_BIT = 11;
  localparam int RSEEN_BIT   = 10;
  localparam int SYNC_LO     = 2;

  typedef struct packed {
    logic          wr;
    logic [7:0]    off;
    logic [DW-1:0] wdata;
  } regacc_t;
endpackage

// File: rtl/irqagg_sticky.sv
module irqagg_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      stat_d[i] = set_i[i] | (stat_q[i] & ~(clr_en_i & clr_i[i]));
    end

    // R5 / R7: a set in the clearing cycle wins
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> stat_o[i]);
    // R3: a pending bit only goes away through a clear write
    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[i] && !(clr_en_i && clr_i[i])) |=> stat_o[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irqagg_hc_regs.sv
module irqagg_hc_regs
  import irqagg_pkg::*;
#(
  parameter int NSER = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  regacc_t         acc_i,
  input  logic [NSER-1:0] serirq_i,
  input  logic            rseen_i,
  input  logic [5:0]      sync_err_i,
  input  logic [1:0]      bm_req_i,
  output logic [DW-1:0]   rdata_o,
  output logic            hit_o,
  output logic            req_o
);
  localparam int SER_LO = DW - NSER;

  logic [DW-1:0] segsel_q, segsel_d;
  logic [DW-1:0] fwsize_q, fwsize_d;
  logic [DW-1:0] ctrl_q,   ctrl_d;
  logic [DW-1:0] mask_q,   mask_d;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] stat;
  logic          stat_clr;

  always_comb begin
    segsel_d = segsel_q;
    fwsize_d = fwsize_q;
    ctrl_d   = ctrl_q;
    mask_d   = mask_q;
    if (acc_i.wr) begin
      case (acc_i.off)
        OFF_SEGSEL: segsel_d = acc_i.wdata;
        OFF_FWSIZE: fwsize_d = acc_i.wdata;
        OFF_SCTRL:  ctrl_d   = acc_i.wdata;
        OFF_HMASK:  mask_d   = acc_i.wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      segsel_q <= '0;
      fwsize_q <= FWSIZE_RST;
      ctrl_q   <= '0;
      mask_q   <= '0;
    end else begin
      segsel_q <= segsel_d;
      fwsize_q <= fwsize_d;
      ctrl_q   <= ctrl_d;
      mask_q   <= mask_d;
    end
  end

  // source-to-status-bit mapping; line n lands on bit DW-1-n
  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NSER; n++) set_vec[DW-1-n] = serirq_i[n];
    set_vec[RSEEN_BIT]            = rseen_i;
    set_vec[SYNC_LO+5:SYNC_LO]    = sync_err_i;
    set_vec[1:0]                  = bm_req_i;
  end

  assign stat_clr = acc_i.wr && (acc_i.off == OFF_HSTAT);

  irqagg_sticky #(.W(DW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_en_i (stat_clr),
    .clr_i    (acc_i.wdata),
    .stat_o   (stat)
  );

  assign req_o = ctrl_q[EN_BIT] & (|(stat & mask_q));

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '1;
    case (acc_i.off)
      OFF_SEGSEL: rdata_o = segsel_q;
      OFF_FWSIZE: rdata_o = fwsize_q;
      OFF_SCTRL:  rdata_o = ctrl_q;
      OFF_HMASK:  rdata_o = mask_q;
      OFF_HSTAT:  rdata_o = stat;
      OFF_ERRADR: rdata_o = '0;
      default:    hit_o   = 1'b0;
    endcase
  end

  // R2: control word moves only on a write to its offset
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_i.wr && acc_i.off == OFF_SCTRL) |=> $stable(ctrl_q));
  // R6: no request while the enable bit is off
  a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[EN_BIT] |-> !req_o);
  // R4: unused status bits stay clear
  a_r4_holes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[SER_LO-1:RSEEN_BIT+1] == '0) && (stat[RSEEN_BIT-1:SYNC_LO+6] == '0));
endmodule

// File: rtl/irqagg_l2_regs.sv
module irqagg_l2_regs
  import irqagg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  regacc_t       acc_i,
  input  logic          req_i,
  output logic [DW-1:0] rdata_o,
  output logic          hit_o,
  output logic          irq_o
);
  logic [DW-1:0] route0_q, route0_d;
  logic [DW-1:0] route1_q, route1_d;
  logic [DW-1:0] mask_q,   mask_d;
  logic [DW-1:0] pol_q,    pol_d;
  logic [DW-1:0] in_q,     in_d;
  logic [DW-1:0] stat;
  logic          stat_clr;

  always_comb begin
    route0_d = route0_q;
    route1_d = route1_q;
    mask_d   = mask_q;
    pol_d    = pol_q;
    if (acc_i.wr) begin
      case (acc_i.off)
        OFF_ROUTE0: route0_d = acc_i.wdata;
        OFF_ROUTE1: route1_d = acc_i.wdata;
        OFF_LMASK:  mask_d   = acc_i.wdata;
        OFF_LPOL:   pol_d    = acc_i.wdata;
        default: ;
      endcase
    end
    in_d              = '0;
    in_d[CASCADE_BIT] = req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route0_q <= '0;
      route1_q <= '0;
      mask_q   <= '0;
      pol_q    <= '0;
      in_q     <= '0;
    end else begin
      route0_q <= route0_d;
      route1_q <= route1_d;
      mask_q   <= mask_d;
      pol_q    <= pol_d;
      in_q     <= in_d;
    end
  end

  assign stat_clr = acc_i.wr && (acc_i.off == OFF_LSTAT);

  irqagg_sticky #(.W(DW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (in_q & mask_q),
    .clr_en_i (stat_clr),
    .clr_i    (acc_i.wdata),
    .stat_o   (stat)
  );

  assign irq_o = |stat;

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = '1;
    case (acc_i.off)
      OFF_ROUTE0: rdata_o = route0_q;
      OFF_ROUTE1: rdata_o = route1_q;
      OFF_LSTAT:  rdata_o = stat;
      OFF_LMASK:  rdata_o = mask_q;
      OFF_LPOL:   rdata_o = pol_q;
      OFF_LIN:    rdata_o = in_q;
      default:    hit_o   = 1'b0;
    endcase
  end

  // R6: a level-one request reaches level-two status two clocks later if unmasked
  a_r6_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_i) && mask_q[CASCADE_BIT]) |=> stat[CASCADE_BIT]);
  // R8: the output stays up until software clears level-two status
  a_r8_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stat_clr) |=> irq_o);
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
  import irqagg_pkg::*;
#(
  parameter int NSER   = 17,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSER-1:0]   serirq_lvl,
  input  logic              lreset_seen,
  input  logic [5:0]        sync_err,
  input  logic [1:0]        bm_req,
  output logic              irq_out
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic          win_hc;
  regacc_t       hc_acc, l2_acc;
  logic [DW-1:0] hc_rdata, l2_rdata;
  logic          hc_hit, l2_hit;
  logic          hc_req;
  logic          rd_en;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rvalid_q, rvalid_d;

  assign win_hc = bus_addr[ADDR_W-1];

  always_comb begin
    hc_acc.wr    = bus_req & bus_wr & win_hc;
    hc_acc.off   = bus_addr[7:0];
    hc_acc.wdata = bus_wdata;
    l2_acc.wr    = bus_req & bus_wr & ~win_hc;
    l2_acc.off   = bus_addr[7:0];
    l2_acc.wdata = bus_wdata;
  end

  irqagg_hc_regs #(.NSER(NSER)) u_hc (
    .clk        (clk),
    .rst_n      (rst_ni),
    .acc_i      (hc_acc),
    .serirq_i   (serirq_lvl),
    .rseen_i    (lreset_seen),
    .sync_err_i (sync_err),
    .bm_req_i   (bm_req),
    .rdata_o    (hc_rdata),
    .hit_o      (hc_hit),
    .req_o      (hc_req)
  );

  irqagg_l2_regs u_l2 (
    .clk     (clk),
    .rst_n   (rst_ni),
    .acc_i   (l2_acc),
    .req_i   (hc_req),
    .rdata_o (l2_rdata),
    .hit_o   (l2_hit),
    .irq_o   (irq_out)
  );

  assign rd_en = bus_req & ~bus_wr;

  always_comb begin
    rdata_d  = rdata_q;
    rvalid_d = rd_en;
    if (rd_en) rdata_d = win_hc ? hc_rdata : l2_rdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R2: every read request is answered on the next clock
  a_r2_rvalid_next: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en |=> bus_rvalid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> !bus_rvalid);
  // R10: reads that neither window claims return all ones
  a_r10_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && !(win_hc ? hc_hit : l2_hit)) |=> (bus_rdata == '1));
endmodule

// File: tb/irq_cascade_agg_test.sv
`timescale 1ns/1ps
module irq_cascade_agg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [16:0] serirq_lvl;
  logic        lreset_seen;
  logic [5:0]  sync_err;
  logic [1:0]  bm_req;
  logic        irq_out;

  always #2.5 clk = ~clk;

  irq_cascade_agg uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .serirq_lvl(serirq_lvl),
    .lreset_seen(lreset_seen), .sync_err(sync_err), .bm_req(bm_req),
    .irq_out(irq_out)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 0;

  localparam logic [8:0] L1 = 9'h100;
  localparam logic [8:0] L2 = 9'h000;

  // monitor: compare each returned read with the queued expectation
  always @(negedge clk) begin
    if (bus_rvalid) begin
      n_vec++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected read data actual=%08h expected=none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_vec++;
    if (irq_out !== e) begin
      n_bad++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, e);
    end
  endtask

  task automatic pulse_line(input int n);
    @(negedge clk);
    serirq_lvl[n] = 1'b1;
    @(negedge clk);
    serirq_lvl[n] = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    serirq_lvl = '0; lreset_seen = 1'b0; sync_err = '0; bm_req = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 reset");
    rd(L1 | 9'h28, 32'h0200_0000, "R1 fw size reset");
    rd(L1 | 9'h30, 32'h0, "R1 control reset");
    rd(L1 | 9'h38, 32'h0, "R1 l1 status reset");
    rd(L2 | 9'h50, 32'h0, "R1 l2 status reset");
    rd(L2 | 9'h5C, 32'h0, "R1 l2 input reset");
    rd(L2 | 9'h08, 32'h0, "R1 route reset");

    // R2 plain read/write words
    wr(L1 | 9'h24, 32'hA5A5_0001);
    wr(L1 | 9'h28, 32'h0700_0000);
    wr(L1 | 9'h30, 32'h4200_0000);  // quiet mode, 8-clock start, disabled
    wr(L2 | 9'h08, 32'h0000_1234);
    wr(L2 | 9'h0C, 32'hCAFE_0000);
    wr(L2 | 9'h58, 32'hFFFF_FFFF);
    rd(L1 | 9'h24, 32'hA5A5_0001, "R2 segment select");
    rd(L1 | 9'h28, 32'h0700_0000, "R2 fw size");
    rd(L1 | 9'h30, 32'h4200_0000, "R2 control");
    rd(L2 | 9'h08, 32'h0000_1234, "R2 route0");
    rd(L2 | 9'h0C, 32'hCAFE_0000, "R2 route1");
    rd(L2 | 9'h58, 32'hFFFF_FFFF, "R2 polarity");

    // R3 serial lines latch on high level
    pulse_line(0);
    pulse_line(16);
    settle();
    rd(L1 | 9'h38, 32'h8000_8000, "R3 lines 0 and 16");
    pulse_line(5);
    settle();
    rd(L1 | 9'h38, 32'h8400_8000, "R3 line 5 sticky");

    // R4 events
    @(negedge clk);
    lreset_seen = 1'b1; sync_err = 6'b100001; bm_req = 2'b10;
    @(negedge clk);
    lreset_seen = 1'b0; sync_err = '0; bm_req = '0;
    settle();
    rd(L1 | 9'h38, 32'h8400_8486, "R4 event bits");

    // R6 enable gates the cascade
    wr(L1 | 9'h34, 32'h8000_0000);
    settle();
    rd(L2 | 9'h5C, 32'h0, "R6 disabled no input");
    chk_irq(1'b0, "R6 disabled");
    wr(L1 | 9'h30, 32'hC200_0000);
    settle();
    rd(L2 | 9'h5C, 32'h0000_0800, "R6 input bit 11");
    rd(L2 | 9'h50, 32'h0, "R7 masked off at level two");
    chk_irq(1'b0, "R7 masked");

    // R7 / R8 level-two latching and output, polarity all ones
    wr(L2 | 9'h54, 32'h0000_0800);
    settle();
    rd(L2 | 9'h50, 32'h0000_0800, "R7 status latched");
    chk_irq(1'b1, "R8 output high with polarity set");

    // R5 level-one clear; level-two stays latched
    wr(L1 | 9'h38, 32'h0);
    settle();
    rd(L1 | 9'h38, 32'h8400_8486, "R5 zero write keeps bits");
    wr(L1 | 9'h38, 32'h8000_0000);
    settle();
    rd(L1 | 9'h38, 32'h0400_8486, "R5 clear bit 31");
    rd(L2 | 9'h5C, 32'h0, "R6 input follows request");
    rd(L2 | 9'h50, 32'h0000_0800, "R7 sticky after input drop");
    chk_irq(1'b1, "R8 still high");
    wr(L2 | 9'h50, 32'h0000_0800);
    settle();
    rd(L2 | 9'h50, 32'h0, "R7 clear");
    chk_irq(1'b0, "R8 low after clear");

    // R5 collision: line held high across its clear
    @(negedge clk); serirq_lvl[3] = 1'b1;
    wr(L1 | 9'h38, 32'h1000_0000);
    repeat (2) @(negedge clk);
    serirq_lvl[3] = 1'b0;
    settle();
    rd(L1 | 9'h38, 32'h1400_8486, "R5 set wins over clear");
    wr(L1 | 9'h38, 32'h1000_0000);
    settle();
    rd(L1 | 9'h38, 32'h0400_8486, "R5 clear after source drop");

    // R7 collision: request held active across level-two clear
    wr(L1 | 9'h34, 32'h0400_0000);
    settle();
    wr(L2 | 9'h50, 32'h0000_0800);
    settle();
    rd(L2 | 9'h50, 32'h0000_0800, "R7 set wins over clear");
    chk_irq(1'b1, "R8 high during collision");
    wr(L1 | 9'h34, 32'h0);
    settle();
    wr(L2 | 9'h50, 32'h0000_0800);
    settle();
    rd(L2 | 9'h50, 32'h0, "R7 clear after request drop");
    chk_irq(1'b0, "R8 low at end");

    // R9 error address, R6 read-only input
    wr(L1 | 9'h40, 32'hFFFF_FFFF);
    rd(L1 | 9'h40, 32'h0, "R9 error address reads zero");
    wr(L2 | 9'h5C, 32'hFFFF_FFFF);
    rd(L2 | 9'h5C, 32'h0, "R6 input ignores writes");

    // R10 unmapped and misaligned
    rd(L1 | 9'h44, 32'hFFFF_FFFF, "R10 unmapped l1");
    rd(L1 | 9'h2C, 32'hFFFF_FFFF, "R10 unmapped l1 gap");
    rd(L2 | 9'h00, 32'hFFFF_FFFF, "R10 unmapped l2");
    rd(L1 | 9'h26, 32'hFFFF_FFFF, "R10 misaligned read");
    wr(L1 | 9'h25, 32'h0);
    rd(L1 | 9'h24, 32'hA5A5_0001, "R10 misaligned write ignored");
    wr(L2 | 9'h60, 32'h0);
    wr(L2 | 9'h09, 32'h0);
    rd(L2 | 9'h08, 32'h0000_1234, "R10 unmapped write ignored");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing read responses actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule